// File: doc/BRIEF.md
# Accumulator ALU with Status Flags

This block is the arithmetic and logic datapath of a small 8-bit processor. It owns the accumulator register. It also owns an 8-bit status register with five meaningful bits: sign, zero, auxiliary (nibble) carry, parity and carry.

On every cycle where the write enable is high, one operation is applied. The operation combines the accumulator with a second byte, which can come from a register or an immediate field. The result is written back into the accumulator, and the status register is updated according to the rules of that operation. Both registers drive the outputs directly.

The operations are add, subtract, increment, decrement, AND, OR, XOR, complement, a load of the operand, and four rotates. Two rotates copy the bit that falls off the end into both the carry flag and the vacated bit (around the carry). The other two pass the old carry into the vacated bit (through the carry).

Top module: `acc_alu`

## Requirements
- R1: While `rst_ni` is low, `acc_o` and `flags_o` are both 0x00.
- R2: `flags_o` bit 7 is sign (result bit 7), bit 6 is zero, bit 4 is auxiliary carry, bit 2 is parity (set when the result holds an even number of ones) and bit 0 is carry; bits 5, 3 and 1 always read 0.
- R3: With `op_i`=0 (add), the accumulator becomes acc+operand modulo 256. Carry is set to the carry out of bit 7 and auxiliary carry to the carry out of bit 3. Sign, zero and parity follow the result.
- R4: With `op_i`=1 (subtract), the accumulator becomes acc-operand modulo 256. Carry is set exactly when the operand is larger than the accumulator as an unsigned value. Auxiliary carry is set when acc[3:0] >= operand[3:0]. Sign, zero and parity follow the result.
- R5: With `op_i`=2 (increment) or 3 (decrement), the accumulator changes by +1 or -1 modulo 256 and the carry flag keeps its value. Auxiliary carry is set when the old low nibble was 0xF (increment) or was not 0x0 (decrement). Sign, zero and parity follow the result.
- R6: With `op_i`=4, 5 or 6 (AND, OR, XOR against the operand), carry and auxiliary carry are cleared, and sign, zero and parity follow the result.
- R7: With `op_i`=7 (complement), the accumulator is inverted bitwise and no flag changes.
- R8: With `op_i`=8 (rotate left around carry) or 9 (rotate right around carry), the bit shifted out goes to both the carry flag and the vacated bit; no other flag changes.
- R9: With `op_i`=10 (rotate left through carry) or 11 (rotate right through carry), the old carry enters the vacated bit and the bit shifted out becomes the carry; no other flag changes.
- R10: With `op_i`=12 (load), the accumulator takes the operand and no flag changes.
- R11: When `we_i` is low, or when `op_i` is 13, 14 or 15, neither the accumulator nor the flags change.
- R12: A result and its flags appear on `acc_o` and `flags_o` after the first rising clock edge at which `we_i` is sampled high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| we_i | input | 1 | Apply `op_i` at this edge |
| op_i | input | 4 | Operation code |
| operand_i | input | 8 | Second operand (register or immediate byte) |
| acc_o | output | 8 | Accumulator register |
| flags_o | output | 8 | Status register |

## Verification
Both registers drive the ports directly, so a wrong accumulator value or a wrong flag bit shows at the very next sample after the edge that wrote it. The exception is a corrupted carry bit left behind by an increment, decrement, complement or load. Such an error stays visible on `flags_o` but only spreads into the data once a rotate through carry consumes it, so the bench checks the full flag byte after every operation. Vectors are set up with both carry polarities, so that an error in carry preservation or in the rotate source is caught in the same cycle.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

  typedef enum logic [3:0] {
    ALU_ADD    = 4'd0,
    ALU_SUB    = 4'd1,
    ALU_INC    = 4'd2,
    ALU_DEC    = 4'd3,
    ALU_AND    = 4'd4,
    ALU_OR     = 4'd5,
    ALU_XOR    = 4'd6,
    ALU_NOT    = 4'd7,
    ALU_ROTL   = 4'd8,
    ALU_ROTR   = 4'd9,
    ALU_ROTL_C = 4'd10,
    ALU_ROTR_C = 4'd11,
    ALU_LOAD   = 4'd12
  } alu_op_e;

  localparam int FLAG_W = 8;
  localparam int FLG_S  = 7;
  localparam int FLG_Z  = 6;
  localparam int FLG_H  = 4;
  localparam int FLG_P  = 2;
  localparam int FLG_C  = 0;

  function automatic logic [FLAG_W-1:0] pack_flags(input logic s, input logic z,
                                                   input logic h, input logic p,
                                                   input logic c);
    logic [FLAG_W-1:0] f;
    f        = '0;
    f[FLG_S] = s;
    f[FLG_Z] = z;
    f[FLG_H] = h;
    f[FLG_P] = p;
    f[FLG_C] = c;
    return f;
  endfunction

endpackage

// File: rtl/acc_alu_arith.sv
// Shared adder: a + (b or ~b) + cin, with the carry out of the low half exposed.
module acc_alu_arith #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             inv_b_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o,
  output logic             half_o
);
  localparam int LO = WIDTH / 2;
  localparam int HI = WIDTH - LO;

  logic [WIDTH-1:0] b_eff;
  logic [LO:0]      lo_sum;
  logic [HI:0]      hi_sum;

  assign b_eff  = inv_b_i ? ~b_i : b_i;
  assign lo_sum = {1'b0, a_i[LO-1:0]} + {1'b0, b_eff[LO-1:0]} + {{LO{1'b0}}, cin_i};
  assign hi_sum = {1'b0, a_i[WIDTH-1:LO]} + {1'b0, b_eff[WIDTH-1:LO]}
                + {{HI{1'b0}}, lo_sum[LO]};

  assign sum_o  = {hi_sum[HI-1:0], lo_sum[LO-1:0]};
  assign cout_o = hi_sum[HI];
  assign half_o = lo_sum[LO];
endmodule

// File: rtl/acc_alu_logic.sv
module acc_alu_logic
  import acc_alu_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  alu_op_e          op_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             carry_i,
  output logic [WIDTH-1:0] res_o,
  output logic             carry_o
);
  localparam int MSB = WIDTH - 1;

  always_comb begin
    res_o   = a_i;
    carry_o = carry_i;
    unique case (op_i)
      ALU_AND:    res_o = a_i & b_i;
      ALU_OR:     res_o = a_i | b_i;
      ALU_XOR:    res_o = a_i ^ b_i;
      ALU_NOT:    res_o = ~a_i;
      ALU_ROTL:   begin res_o = {a_i[MSB-1:0], a_i[MSB]}; carry_o = a_i[MSB]; end
      ALU_ROTR:   begin res_o = {a_i[0], a_i[MSB:1]};     carry_o = a_i[0];   end
      ALU_ROTL_C: begin res_o = {a_i[MSB-1:0], carry_i};  carry_o = a_i[MSB]; end
      ALU_ROTR_C: begin res_o = {carry_i, a_i[MSB:1]};    carry_o = a_i[0];   end
      default:    ;
    endcase
  end
endmodule

// File: rtl/acc_alu_status.sv
module acc_alu_status #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] res_i,
  output logic             sign_o,
  output logic             zero_o,
  output logic             parity_o
);
  assign sign_o   = res_i[WIDTH-1];
  assign zero_o   = (res_i == '0);
  assign parity_o = ~^res_i;
endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_alu_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [3:0]       op_i,
  input  logic [WIDTH-1:0] operand_i,
  output logic [WIDTH-1:0] acc_o,
  output logic [7:0]       flags_o
);
  alu_op_e           op;
  logic [WIDTH-1:0]  acc_q, acc_d;
  logic [FLAG_W-1:0] flags_q, flags_d;

  logic [WIDTH-1:0]  add_b, add_sum, log_res, res;
  logic              add_inv, add_cin, add_cout, add_half, log_carry;
  logic              st_s, st_z, st_p;
  logic              is_arith, is_bool;

  assign op       = alu_op_e'(op_i);
  assign is_arith = op inside {ALU_ADD, ALU_SUB, ALU_INC, ALU_DEC};
  assign is_bool  = op inside {ALU_AND, ALU_OR, ALU_XOR};

  // add: b,+0  sub: ~b,+1  inc: 0,+1  dec: ~0,+0
  always_comb begin
    add_b   = operand_i;
    add_inv = 1'b0;
    add_cin = 1'b0;
    unique case (op)
      ALU_SUB: begin add_inv = 1'b1; add_cin = 1'b1; end
      ALU_INC: begin add_b = '0; add_cin = 1'b1; end
      ALU_DEC: begin add_b = '0; add_inv = 1'b1; end
      default: ;
    endcase
  end

  acc_alu_arith #(.WIDTH(WIDTH)) u_arith (
    .a_i    (acc_q),
    .b_i    (add_b),
    .inv_b_i(add_inv),
    .cin_i  (add_cin),
    .sum_o  (add_sum),
    .cout_o (add_cout),
    .half_o (add_half)
  );

  acc_alu_logic #(.WIDTH(WIDTH)) u_logic (
    .op_i   (op),
    .a_i    (acc_q),
    .b_i    (operand_i),
    .carry_i(flags_q[FLG_C]),
    .res_o  (log_res),
    .carry_o(log_carry)
  );

  assign res = is_arith ? add_sum : log_res;

  acc_alu_status #(.WIDTH(WIDTH)) u_status (
    .res_i   (res),
    .sign_o  (st_s),
    .zero_o  (st_z),
    .parity_o(st_p)
  );

  always_comb begin
    acc_d   = acc_q;
    flags_d = flags_q;
    unique case (op)
      ALU_ADD: begin acc_d = res; flags_d = pack_flags(st_s, st_z, add_half, st_p, add_cout);  end
      ALU_SUB: begin acc_d = res; flags_d = pack_flags(st_s, st_z, add_half, st_p, ~add_cout); end
      ALU_INC, ALU_DEC: begin
        acc_d   = res;
        flags_d = pack_flags(st_s, st_z, add_half, st_p, flags_q[FLG_C]);
      end
      ALU_AND, ALU_OR, ALU_XOR: begin
        acc_d   = res;
        flags_d = pack_flags(st_s, st_z, 1'b0, st_p, 1'b0);
      end
      ALU_NOT: acc_d = res;
      ALU_ROTL, ALU_ROTR, ALU_ROTL_C, ALU_ROTR_C: begin
        acc_d          = res;
        flags_d[FLG_C] = log_carry;
      end
      ALU_LOAD: acc_d = operand_i;
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q   <= '0;
      flags_q <= '0;
    end else if (we_i) begin
      acc_q   <= acc_d;
      flags_q <= flags_d;
    end
  end

  assign acc_o   = acc_q;
  assign flags_o = flags_q;

  assert_hold_idle_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(acc_q) && $stable(flags_q));

  assert_zero_parity_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i && (is_arith || is_bool) |=>
      flags_q[FLG_Z] == (acc_q == '0) && flags_q[FLG_P] == ~^acc_q);

  assert_sub_borrow_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i && op == ALU_SUB |=> flags_q[FLG_C] == ($past(operand_i) > $past(acc_q)));

  assert_step_keeps_carry_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i && (op == ALU_INC || op == ALU_DEC) |=> flags_q[FLG_C] == $past(flags_q[FLG_C]));

  assert_bool_clears_carry_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i && is_bool |=> !flags_q[FLG_C] && !flags_q[FLG_H]);

  assert_not_keeps_flags_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i && op == ALU_NOT |=> $stable(flags_q) && acc_q == ~$past(acc_q));

  assert_rotl_copy_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i && op == ALU_ROTL |=>
      flags_q[FLG_C] == $past(acc_q[WIDTH-1]) && acc_q[0] == $past(acc_q[WIDTH-1]));

  assert_rotr_thru_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i && op == ALU_ROTR_C |=>
      acc_q[WIDTH-1] == $past(flags_q[FLG_C]) && flags_q[FLG_C] == $past(acc_q[0]));
endmodule

// File: tb/acc_alu_bench.sv
module acc_alu_bench;
  localparam logic [3:0] OP_ADD = 4'd0,  OP_SUB = 4'd1,  OP_INC = 4'd2,  OP_DEC = 4'd3;
  localparam logic [3:0] OP_AND = 4'd4,  OP_OR  = 4'd5,  OP_XOR = 4'd6,  OP_NOT = 4'd7;
  localparam logic [3:0] OP_RL  = 4'd8,  OP_RR  = 4'd9,  OP_RLC = 4'd10, OP_RRC = 4'd11;
  localparam logic [3:0] OP_LD  = 4'd12;

  // {pre_acc, pre_carry, op, operand, exp_acc, exp_flags, req}
  localparam int NVEC = 20;
  localparam logic [40:0] VEC [NVEC] = '{
    {8'h05, 1'b0, OP_ADD, 8'h04, 8'h09, 8'h04, 4'd3},  // R3 plain
    {8'h3A, 1'b0, OP_ADD, 8'hC6, 8'h00, 8'h55, 4'd3},  // R3 wrap, nibble carry
    {8'h7F, 1'b0, OP_ADD, 8'h01, 8'h80, 8'h90, 4'd3},  // R3 sign, odd parity
    {8'h05, 1'b0, OP_SUB, 8'h07, 8'hFE, 8'h81, 4'd4},  // R4 borrow
    {8'h20, 1'b0, OP_SUB, 8'h20, 8'h00, 8'h54, 4'd4},  // R4 equal
    {8'h34, 1'b0, OP_SUB, 8'h12, 8'h22, 8'h14, 4'd4},  // R4 no borrow
    {8'h0F, 1'b1, OP_INC, 8'h00, 8'h10, 8'h11, 4'd5},  // R5 carry kept set
    {8'hFF, 1'b0, OP_INC, 8'h00, 8'h00, 8'h54, 4'd5},  // R5 wrap, carry kept clear
    {8'h00, 1'b1, OP_DEC, 8'h00, 8'hFF, 8'h85, 4'd5},  // R5 wrap down
    {8'h10, 1'b0, OP_DEC, 8'h00, 8'h0F, 8'h04, 4'd5},  // R5 nibble borrow
    {8'hF0, 1'b1, OP_AND, 8'h3C, 8'h30, 8'h04, 4'd6},  // R6
    {8'h81, 1'b1, OP_OR,  8'h02, 8'h83, 8'h80, 4'd6},  // R6
    {8'h55, 1'b1, OP_XOR, 8'h55, 8'h00, 8'h44, 4'd6},  // R6
    {8'h5A, 1'b1, OP_NOT, 8'h00, 8'hA5, 8'h55, 4'd7},  // R7
    {8'h85, 1'b0, OP_RL,  8'h00, 8'h0B, 8'h45, 4'd8},  // R8
    {8'h01, 1'b0, OP_RR,  8'h00, 8'h80, 8'h45, 4'd8},  // R8
    {8'h85, 1'b0, OP_RLC, 8'h00, 8'h0A, 8'h45, 4'd9},  // R9
    {8'h40, 1'b1, OP_RLC, 8'h00, 8'h81, 8'h54, 4'd9},  // R9
    {8'h01, 1'b1, OP_RRC, 8'h00, 8'h80, 8'h55, 4'd9},  // R9
    {8'h02, 1'b0, OP_RRC, 8'h00, 8'h01, 8'h44, 4'd9}   // R9
  };

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       we_i = 1'b0;
  logic [3:0] op_i = 4'd0;
  logic [7:0] operand_i = 8'h00;
  logic [7:0] acc_o, flags_o;

  int n_checks = 0;
  int n_fail   = 0;
  logic [7:0] saved_flags;

  acc_alu u_acc_alu (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (we_i),
    .op_i     (op_i),
    .operand_i(operand_i),
    .acc_o    (acc_o),
    .flags_o  (flags_o)
  );

  always #4 clk_i = ~clk_i;

  task automatic check(input int req, input string what, input logic [7:0] act,
                       input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL R%0d %s: actual %02h expected %02h", req, what, act, exp);
    end
  endtask

  // Inputs change on the falling edge; the result is read on the next falling edge.
  task automatic apply(input logic [3:0] op, input logic [7:0] opnd, input logic en);
    @(negedge clk_i);
    op_i      = op;
    operand_i = opnd;
    we_i      = en;
    @(negedge clk_i);
    we_i      = 1'b0;
  endtask

  // Carry set: FF+01 leaves flags 0x55; carry clear: 00+00 leaves flags 0x44.
  task automatic setup(input logic [7:0] a, input logic c);
    if (c) begin apply(OP_LD, 8'hFF, 1'b1); apply(OP_ADD, 8'h01, 1'b1); end
    else   begin apply(OP_LD, 8'h00, 1'b1); apply(OP_ADD, 8'h00, 1'b1); end
    apply(OP_LD, a, 1'b1);
  endtask

  initial begin
    #(200000 * 8);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    // R1 reset state
    #10;
    check(1, "acc in reset", acc_o, 8'h00);
    check(1, "flags in reset", flags_o, 8'h00);
    @(negedge clk_i);
    rst_ni = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      logic [40:0] v;
      v = VEC[i];
      setup(v[40:33], v[32]);
      apply(v[31:28], v[27:20], 1'b1);
      check(int'(v[3:0]), $sformatf("vec %0d acc", i), acc_o, v[19:12]);   // R12 latency
      check(int'(v[3:0]), $sformatf("vec %0d flags", i), flags_o, v[11:4]); // R2 layout
    end

    // R10 load keeps flags
    setup(8'h00, 1'b1);
    apply(OP_LD, 8'hC3, 1'b1);
    check(10, "load acc", acc_o, 8'hC3);
    check(10, "load flags", flags_o, 8'h55);

    // R11 write enable low
    setup(8'h5A, 1'b0);
    saved_flags = flags_o;
    apply(OP_ADD, 8'h01, 1'b0);
    check(11, "idle acc", acc_o, 8'h5A);
    check(11, "idle flags", flags_o, saved_flags);

    // R11 unused codes 13..15
    for (int k = 13; k < 16; k++) begin
      setup(8'h3C, 1'b1);
      apply(4'(k), 8'hFF, 1'b1);
      check(11, $sformatf("code %0d acc", k), acc_o, 8'h3C);
      check(11, $sformatf("code %0d flags", k), flags_o, 8'h55);
    end

    // R1 reset mid-run
    setup(8'h77, 1'b1);
    @(negedge clk_i);
    rst_ni = 1'b0;
    #2;
    check(1, "acc after reset", acc_o, 8'h00);
    check(1, "flags after reset", flags_o, 8'h00);
    @(negedge clk_i);
    rst_ni = 1'b1;

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule